// File: doc/BRIEF.md
# I/O Port Decoder with Per-Region Wait States

This block sits between a processor's 16-bit I/O port bus and sixteen peripheral regions. The top four address bits pick one region. The low address bits are folded through a mask that belongs to that region, so each peripheral sees only its own aliased offset. The processor access is then stretched to a fixed total length. That length is looked up per region, with one table for reads and another for writes.

A processor issues a request by pulsing `req_valid` for one cycle while the block is idle. The block latches the request and holds exactly one region select high for the whole access. It asserts `req_ready` in the final cycle; for reads, the selected region's data appears on `rsp_rdata` in that same cycle.

A peek flag marks a debugger access. A peek reaches the same region and offset, carries `rgn_peek` so the peripheral can suppress side effects, and completes in a single cycle. A write-freeze input drops ordinary writes entirely. A dropped write is only acknowledged: no region is selected and no wait cycles are added.

Top module: `io_port_decoder`

## Requirements
- R1: The region index is `req_addr[15:12]`. During an access, exactly the one `rgn_sel` bit with that index is high. While idle, all `rgn_sel` bits are low.
- R2: `rgn_offset` equals `req_addr[11:0]` ANDed with the region mask. The masks in hex for regions 0 to 15 are FF, FF, FF, 1FF, FFF, FF, 1F, FF, 7F, FFF, 7F, FFF, FF, 7F, 7F, FFF.
- R3: A non-peek read of region r keeps the select high for N cycles, with N = 2, 2, 2, 4, 3 for regions 0 to 4 and 3 for regions 5 to 15. Counting the cycle after the request cycle as cycle 1, `req_ready` is high only in cycle N.
- R4: A non-peek write uses the write lengths N = 2, 2, 2, 4, 2 for regions 0 to 4 and 3 for regions 5 to 15. A region 4 write is therefore one cycle shorter than a region 4 read.
- R5: In the ready cycle of a read, `rsp_rdata` equals `rgn_rdata[8r+7:8r]` of the selected region r. Whenever `req_ready` is low, `rsp_rdata` is zero.
- R6: During a write access, `rgn_write` is high and `rgn_wdata` carries the request's write data. During a read access, `rgn_write` is low.
- R7: A non-peek write issued while `wr_freeze` is high is dropped. No select rises, `rgn_write` stays low, and `req_ready` pulses in cycle 1. Reads are not affected by `wr_freeze`.
- R8: A peek access (`req_peek` high) holds `rgn_peek` high with the normal select and offset, and completes in one cycle. It is never dropped by `wr_freeze`.
- R9: A request that arrives while an access is in progress is ignored. A new request is accepted in the cycle right after the ready cycle.
- R10: After reset, no select is high, `req_ready` is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_peek | input | 1 | Side-effect-free debugger access |
| req_addr | input | 16 | Port address |
| req_wdata | input | 8 | Write data |
| wr_freeze | input | 1 | Drop ordinary writes |
| req_ready | output | 1 | Access completes in this cycle |
| rsp_rdata | output | 8 | Read data, valid while req_ready is high |
| rgn_sel | output | 16 | One-hot region select |
| rgn_offset | output | 12 | Masked offset inside the region |
| rgn_write | output | 1 | Write strobe for the selected region |
| rgn_peek | output | 1 | Peek flag for the selected region |
| rgn_wdata | output | 8 | Write data to the region |
| rgn_rdata | input | 128 | Read data of all regions, region r at bits 8r+7:8r |

## Verification
On every cycle, the assertions check that the select bus is one-hot while busy and empty while idle. They also check that it holds steady for the whole access, that a frozen write yields an acknowledge with no select, that a peek finishes in one cycle, and that read data is zero outside the ready cycle. Only the bench's scenarios can show the actual length of each region's read and write access, the masked offset values, the data routed back from the right region, and that a request arriving during an access leaves no trace afterwards.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  localparam int REGION_BITS = 4;
  localparam int NUM_REGIONS = 1 << REGION_BITS;
  localparam int OFS_W       = 12;
  localparam int CYC_W       = 3;

  function automatic logic [OFS_W-1:0] region_mask(input logic [REGION_BITS-1:0] r);
    logic [OFS_W-1:0] m;
    case (r)
      4'd3:                        m = 12'h1FF;
      4'd4, 4'd9, 4'd11, 4'd15:    m = 12'hFFF;
      4'd6:                        m = 12'h01F;
      4'd8, 4'd10, 4'd13, 4'd14:   m = 12'h07F;
      default:                     m = 12'h0FF;
    endcase
    return m;
  endfunction

  function automatic logic [CYC_W-1:0] read_len(input logic [REGION_BITS-1:0] r);
    logic [CYC_W-1:0] n;
    if (r < 4'd3)       n = 3'd2;
    else if (r == 4'd3) n = 3'd4;
    else                n = 3'd3;
    return n;
  endfunction

  function automatic logic [CYC_W-1:0] write_len(input logic [REGION_BITS-1:0] r);
    logic [CYC_W-1:0] n;
    if (r < 4'd3 || r == 4'd4) n = 3'd2;
    else if (r == 4'd3)        n = 3'd4;
    else                       n = 3'd3;
    return n;
  endfunction

endpackage

// File: rtl/io_rst_sync.sv
module io_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/io_region_lut.sv
module io_region_lut
  import io_dec_pkg::*;
(
  input  logic [REGION_BITS-1:0] idx,
  input  logic                   write,
  input  logic                   peek,
  output logic [OFS_W-1:0]       mask,
  output logic [CYC_W-1:0]       load
);
  logic [CYC_W-1:0] total;

  always_comb begin
    mask  = region_mask(idx);
    total = write ? write_len(idx) : read_len(idx);
    // a peek is a single-cycle access: counter starts at zero
    load  = peek ? '0 : total - CYC_W'(1);
  end
endmodule

// File: rtl/io_wait_timer.sv
module io_wait_timer #(
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CYC_W-1:0] load,
  output logic             busy,
  output logic             last
);
  logic             busy_q, busy_d;
  logic [CYC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = load;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CYC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign last = busy_q && (cnt_q == '0);

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy);  // R3
  AST_TIMER_END: assert property (@(posedge clk) disable iff (!rst_n)
    last && !start |=> !busy);  // R9
endmodule

// File: rtl/io_sel_decoder.sv
module io_sel_decoder #(
  parameter int IDX_W = 4,
  localparam int N    = 1 << IDX_W
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     sel
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic                          req_peek,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic                          wr_freeze,
  output logic                          req_ready,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic [NUM_REGIONS-1:0]        rgn_sel,
  output logic [OFS_W-1:0]              rgn_offset,
  output logic                          rgn_write,
  output logic                          rgn_peek,
  output logic [DATA_W-1:0]             rgn_wdata,
  input  logic [NUM_REGIONS*DATA_W-1:0] rgn_rdata
);
  localparam int IDX_LSB = ADDR_W - REGION_BITS;

  logic rst_n_s;
  io_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  logic [REGION_BITS-1:0] req_idx;
  logic [OFS_W-1:0]       req_mask;
  logic [CYC_W-1:0]       req_load;
  assign req_idx = req_addr[ADDR_W-1:IDX_LSB];

  io_region_lut u_lut (
    .idx(req_idx), .write(req_write), .peek(req_peek),
    .mask(req_mask), .load(req_load)
  );

  logic busy, last, drop_q, drop_d;
  logic accept, frozen, start;

  assign accept = req_valid && !busy && !drop_q;
  assign frozen = req_write && !req_peek && wr_freeze;
  assign start  = accept && !frozen;
  assign drop_d = accept && frozen;

  io_wait_timer #(.CYC_W(CYC_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .start(start), .load(req_load),
    .busy(busy), .last(last)
  );

  // latched access attributes, next-state / register split
  logic [REGION_BITS-1:0] idx_q, idx_d;
  logic [OFS_W-1:0]       ofs_q, ofs_d;
  logic                   wr_q, wr_d, pk_q, pk_d;
  logic [DATA_W-1:0]      wd_q, wd_d;

  always_comb begin
    idx_d = idx_q;
    ofs_d = ofs_q;
    wr_d  = wr_q;
    pk_d  = pk_q;
    wd_d  = wd_q;
    if (start) begin
      idx_d = req_idx;
      ofs_d = req_addr[OFS_W-1:0] & req_mask;
      wr_d  = req_write;
      pk_d  = req_peek;
      wd_d  = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q  <= '0;
      ofs_q  <= '0;
      wr_q   <= 1'b0;
      pk_q   <= 1'b0;
      wd_q   <= '0;
      drop_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      ofs_q  <= ofs_d;
      wr_q   <= wr_d;
      pk_q   <= pk_d;
      wd_q   <= wd_d;
      drop_q <= drop_d;
    end
  end

  io_sel_decoder #(.IDX_W(REGION_BITS)) u_dec (.en(busy), .idx(idx_q), .sel(rgn_sel));

  assign rgn_offset = ofs_q;
  assign rgn_write  = busy && wr_q;
  assign rgn_peek   = busy && pk_q;
  assign rgn_wdata  = wd_q;
  assign req_ready  = last || drop_q;
  assign rsp_rdata  = (last && !wr_q) ? rgn_rdata[idx_q*DATA_W +: DATA_W] : '0;

  AST_BUSY_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |-> $countones(rgn_sel) == 1);  // R1
  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> rgn_sel == '0);  // R1
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy && !last |=> $stable(rgn_sel) && $stable(rgn_offset));  // R9
  AST_FREEZE_DROP: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept && frozen |=> req_ready && rgn_sel == '0 && !rgn_write);  // R7
  AST_PEEK_ONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    start && req_peek |=> req_ready && rgn_peek);  // R8
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_ready |-> rsp_rdata == '0);  // R5
endmodule

// File: tb/io_port_decoder_test.sv
module io_port_decoder_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write, req_peek, wr_freeze;
  logic [15:0]  req_addr;
  logic [7:0]   req_wdata;
  logic         req_ready;
  logic [7:0]   rsp_rdata;
  logic [15:0]  rgn_sel;
  logic [11:0]  rgn_offset;
  logic         rgn_write, rgn_peek;
  logic [7:0]   rgn_wdata;
  logic [127:0] rgn_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  io_port_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_peek(req_peek), .req_addr(req_addr), .req_wdata(req_wdata),
    .wr_freeze(wr_freeze), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .rgn_sel(rgn_sel), .rgn_offset(rgn_offset), .rgn_write(rgn_write),
    .rgn_peek(rgn_peek), .rgn_wdata(rgn_wdata), .rgn_rdata(rgn_rdata)
  );

  function automatic logic [11:0] exp_mask(input int r);
    case (r)
      3: return 12'h1FF;
      4, 9, 11, 15: return 12'hFFF;
      6: return 12'h01F;
      8, 10, 13, 14: return 12'h07F;
      default: return 12'h0FF;
    endcase
  endfunction

  function automatic int exp_len(input int r, input logic w, input logic pk, input logic frz);
    if (pk) return 1;
    if (w && frz) return 1;
    if (r == 3) return 4;
    if (r < 3) return 2;
    if (r == 4) return w ? 2 : 3;
    return 3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // starts and ends at a negedge; the following negedge may start a new request
  task automatic run_access(input logic [15:0] a, input logic w, input logic pk,
                            input logic frz, input logic [7:0] d);
    int r = int'(a[15:12]);
    int n = exp_len(r, w, pk, frz);
    bit drop = w && frz && !pk;
    int k = 0;
    int got = 0;
    bit sel_ok = 1, ofs_ok = 1, wr_ok = 1, pk_ok = 1, rd_ok = 1;
    logic [7:0] rd_act = '0;
    chk(rgn_sel == 16'h0 && !req_ready, "R9 idle before request", {15'b0, req_ready, rgn_sel}, 32'h0);
    rgn_rdata = {$urandom, $urandom, $urandom, $urandom};
    req_addr = a; req_write = w; req_peek = pk; wr_freeze = frz; req_wdata = d;
    req_valid = 1'b1;
    while (got == 0 && k < 8) begin
      @(negedge clk);
      req_valid = 1'b0;
      k++;
      if (drop) begin
        if (rgn_sel != 0 || rgn_write) sel_ok = 0;
      end else begin
        if (rgn_sel != (16'h1 << r)) sel_ok = 0;
        if (rgn_offset != (a[11:0] & exp_mask(r))) ofs_ok = 0;
        if (rgn_write != w || (w && rgn_wdata != d)) wr_ok = 0;
        if (rgn_peek != pk) pk_ok = 0;
      end
      if (!req_ready && rsp_rdata != 0) rd_ok = 0;
      if (req_ready) begin
        got = k;
        rd_act = rsp_rdata;
      end
    end
    if (drop) begin
      chk(got == 1, "R7 frozen write acknowledged in cycle 1", got, 1);
      chk(sel_ok, "R7 frozen write selects nothing", rgn_sel, 0);
    end else begin
      chk(got == n, pk ? "R8 peek length" : (w ? "R4 write length" : "R3 read length"), got, n);
      chk(sel_ok, "R1 one-hot select", rgn_sel, 32'h1 << r);
      chk(ofs_ok, "R2 masked offset", rgn_offset, a[11:0] & exp_mask(r));
      chk(wr_ok, "R6 write strobe and data", {rgn_write, rgn_wdata}, {w, d});
      chk(pk_ok, "R8 peek flag", rgn_peek, pk);
      if (!w) chk(rd_act == rgn_rdata[r*8 +: 8], "R5 read data", rd_act, rgn_rdata[r*8 +: 8]);
    end
    chk(rd_ok, "R5 read data zero outside ready", rsp_rdata, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_peek = 0; wr_freeze = 0;
    req_addr = '0; req_wdata = '0; rgn_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rgn_sel == 0, "R10 no select after reset", rgn_sel, 0);
    chk(!req_ready, "R10 ready low after reset", req_ready, 0);

    // every region, read and write, with all offset bits set
    for (int r = 0; r < 16; r++) begin
      run_access({r[3:0], 12'hFFF}, 1'b0, 1'b0, 1'b0, 8'h00);
      run_access({r[3:0], 12'hA5C}, 1'b1, 1'b0, 1'b0, 8'(r * 7 + 1));
    end
    // region 4: write shorter than read (R4)
    run_access(16'h4123, 1'b0, 1'b0, 1'b0, 8'h00);
    run_access(16'h4123, 1'b1, 1'b0, 1'b0, 8'h3C);
    // freeze: write dropped, read unaffected (R7)
    run_access(16'h3456, 1'b1, 1'b0, 1'b1, 8'h99);
    run_access(16'h3456, 1'b0, 1'b0, 1'b1, 8'h00);
    // peek read and peek write under freeze (R8)
    run_access(16'h3FFF, 1'b0, 1'b1, 1'b0, 8'h00);
    run_access(16'h6FFF, 1'b1, 1'b1, 1'b1, 8'h77);

    // request during busy is ignored (R9)
    req_addr = 16'h3010; req_write = 0; req_peek = 0; wr_freeze = 0; req_valid = 1;
    @(negedge clk);
    req_addr = 16'h9000; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rgn_sel == 16'h0008, "R9 select unchanged by request while busy", rgn_sel, 16'h0008);
    @(negedge clk);
    @(negedge clk);
    chk(req_ready, "R9 busy-time request does not alter length", req_ready, 1);
    @(negedge clk);
    chk(rgn_sel == 0 && !req_ready, "R9 ignored request left no access", rgn_sel, 0);

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a = 16'($urandom);
      logic w = 1'($urandom);
      logic pk = ($urandom % 4) == 0;
      logic frz = ($urandom % 4) == 0;
      run_access(a, w, pk, frz, 8'($urandom));
    end
    finish_run();
  end
endmodule